// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Controller

This block is the digital side of an integrating analog-to-digital converter. It steers an external integrator through three exclusive controls: a dump switch that empties the integrating capacitor, a switch that applies the unknown input, and a switch that applies the reference. It reads back a zero-crossing comparator and counts clock periods. A start request first runs a short dump window. An integrate phase of exactly 2^RES_W clocks follows. The block then applies the reference and counts until the comparator reports that the integrator has returned to zero.

The final count is proportional to Vin/Vref scaled by the integrate length. It is latched into a result register and announced by a single-cycle valid strobe. Conversion time is the constant dump and integrate time plus a de-integrate time that grows with the input. If the integrator does not cross zero within 2^RES_W reference clocks, the conversion ends with a full-scale result and an overrange flag. CLR_CYC must lie between 1 and 2^RES_W.

Top module: `dslope_ctrl`

## Requirements
- R1: While reset is asserted, and in the idle state after it, dump_o, sel_in_o, sel_ref_o, busy_o, valid_o and ovr_o are 0 and result_o is 0. A reset during a conversion abandons it.
- R2: A start_i pulse sampled in idle holds dump_o high for exactly CLR_CYC cycles, then sel_in_o high for exactly 2^RES_W cycles.
- R3: sel_ref_o rises in the cycle sel_in_o falls and stays high until the conversion ends. At most one of dump_o, sel_in_o and sel_ref_o is high in any cycle.
- R4: cmp_i = 1 means the integrator output is at or below zero. It passes through a two-flop synchronizer. result_o is the number of de-integrate cycles elapsed before the first synchronized sample showing 1, including the two-cycle synchronizer lag.
- R5: If the de-integrate count reaches 2^RES_W with no synchronized crossing, result_o = 2^RES_W and ovr_o = 1. A crossing seen at that same count takes precedence and gives ovr_o = 0. result_o never exceeds 2^RES_W.
- R6: valid_o is high for exactly one cycle per conversion. Counting the start-sampling edge as edge 0, valid_o is high after edge CLR_CYC + 2^RES_W + result + 1.
- R7: result_o and ovr_o change only in the cycle valid_o is high and hold their value otherwise.
- R8: busy_o is high from the first cycle after start is accepted up to and including the valid cycle. start_i pulses while busy are ignored and do not change the result or the timing.
- R9: If the synchronized comparator already shows a crossing on the first de-integrate cycle (zero input), result_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled in idle |
| cmp_i | input | 1 | Zero-crossing comparator, 1 = integrator at or below zero (asynchronous) |
| dump_o | output | 1 | Discharge integrator capacitor |
| sel_in_o | output | 1 | Connect unknown input to integrator |
| sel_ref_o | output | 1 | Connect reference to integrator |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe, new result available |
| result_o | output | RES_W+1 | Latched de-integrate count |
| ovr_o | output | 1 | Latched overrange flag |

## Verification
The assertions assume the integrator behaves physically. During the input phase it moves away from zero by a non-negative step each clock. Under the reference it falls monotonically, and the dump switch returns it to zero. They also assume that cmp_i is a level and not a glitch train. The bench meets these conditions with a behavioural integrator driven from the block's own select outputs. That integrator adds a non-negative input value per clock, subtracts a fixed reference step, and derives the comparator from the accumulated value. Expected counts therefore follow directly from the input value, the reference step and the synchronizer lag.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  // Conversion phases; order carries no meaning outside the controller.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DUMP  = 3'd1,
    ST_INTEG = 3'd2,
    ST_DEINT = 3'd3,
    ST_DONE  = 3'd4
  } conv_state_e;

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dslope_timer.sv
module dslope_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  assign cnt_ce = clr_i | en_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R5: the controller never asks the counter to step past its top value
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |-> (cnt_q != {W{1'b1}}));

endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int RES_W   = 8,
  parameter int CLR_CYC = 4,
  parameter int CNT_W   = RES_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cross_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             dump_o,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ovr_o
);

  localparam int              INT_LEN   = 1 << RES_W;
  localparam logic [CNT_W-1:0] DUMP_LAST = CNT_W'(CLR_CYC - 1);
  localparam logic [CNT_W-1:0] INT_LAST  = CNT_W'(INT_LEN - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(INT_LEN);

  conv_state_e      state_q, state_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             ovr_q, ovr_d;
  logic             res_ld;

  // Next-state, counter control and result capture
  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_en_o  = 1'b0;
    res_d     = res_q;
    ovr_d     = ovr_q;
    res_ld    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr_o = 1'b1;
        if (start_i) state_d = ST_DUMP;
      end
      ST_DUMP: begin
        if (cnt_i == DUMP_LAST) begin
          cnt_clr_o = 1'b1;
          state_d   = ST_INTEG;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      ST_INTEG: begin
        if (cnt_i == INT_LAST) begin
          cnt_clr_o = 1'b1;
          state_d   = ST_DEINT;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      ST_DEINT: begin
        if (cross_i) begin
          res_d     = cnt_i;
          ovr_d     = 1'b0;
          res_ld    = 1'b1;
          cnt_clr_o = 1'b1;
          state_d   = ST_DONE;
        end else if (cnt_i == FULL) begin
          res_d     = FULL;
          ovr_d     = 1'b1;
          res_ld    = 1'b1;
          cnt_clr_o = 1'b1;
          state_d   = ST_DONE;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      ST_DONE: begin
        cnt_clr_o = 1'b1;
        state_d   = ST_IDLE;
      end
      default: begin
        cnt_clr_o = 1'b1;
        state_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
    end else if (res_ld) begin
      res_q <= res_d;
      ovr_q <= ovr_d;
    end
  end

  assign dump_o    = (state_q == ST_DUMP);
  assign sel_in_o  = (state_q == ST_INTEG);
  assign sel_ref_o = (state_q == ST_DEINT);
  assign busy_o    = (state_q != ST_IDLE);
  assign valid_o   = (state_q == ST_DONE);
  assign result_o  = res_q;
  assign ovr_o     = ovr_q;

  // R6: strobe lasts one cycle
  p_valid_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R5: overrange always reports full scale
  p_ovr_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ovr_o) |-> (result_o == FULL));

  // R5: result bounded by the integrate length
  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (result_o <= FULL));

  // R7: outputs hold between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(result_o) && $stable(ovr_o)));

  // R3: reference follows the input phase directly
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_in_o) |-> sel_ref_o);

  // R2: integration is always preceded by the dump window
  p_dump_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_in_o) |-> $past(dump_o));

  // R3: switch controls mutually exclusive
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dump_o, sel_in_o, sel_ref_o}));

  // R8: once busy, stays busy until the strobe cycle has passed
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !valid_o) |=> busy_o);

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl #(
  parameter int RES_W       = 8,
  parameter int CLR_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             dump_o,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W:0]   result_o,
  output logic             ovr_o
);

  localparam int CNT_W = RES_W + 1;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             cross_s;
  logic             cnt_clr;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  dslope_sync #(
    .STAGES(SYNC_STAGES)
  ) u_cmp_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  (cmp_i),
    .q_o  (cross_s)
  );

  dslope_timer #(
    .W(CNT_W)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr_i(cnt_clr),
    .en_i (cnt_en),
    .cnt_o(cnt)
  );

  dslope_fsm #(
    .RES_W  (RES_W),
    .CLR_CYC(CLR_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .cross_i  (cross_s),
    .cnt_i    (cnt),
    .cnt_clr_o(cnt_clr),
    .cnt_en_o (cnt_en),
    .dump_o   (dump_o),
    .sel_in_o (sel_in_o),
    .sel_ref_o(sel_ref_o),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .result_o (result_o),
    .ovr_o    (ovr_o)
  );

endmodule

// File: tb/dslope_ctrl_tb.sv
module dslope_ctrl_tb;

  localparam int RES_W   = 8;
  localparam int CLR_CYC = 4;
  localparam int FULL    = 1 << RES_W;
  localparam int VREF    = FULL;
  localparam int NV      = 8;

  // Input value per clock, expected result, expected overrange
  localparam int T_VIN [NV] = '{0, 1, 37, 128, 200, 254, 255, 300};
  localparam int T_RES [NV] = '{0, 3, 39, 130, 202, 256, 256, 256};
  localparam int T_OVR [NV] = '{0, 0, 0,  0,   0,   0,   1,   1};

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic           cmp;
  logic           dump, sin, sref, busy, valid, ovr;
  logic [RES_W:0] res;
  int             vin_u;
  int             v_acc;
  int             n_chk = 0;
  int             n_fail = 0;

  always #5 clk = ~clk;

  dslope_ctrl #(.RES_W(RES_W), .CLR_CYC(CLR_CYC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .dump_o(dump), .sel_in_o(sin), .sel_ref_o(sref), .busy_o(busy),
    .valid_o(valid), .result_o(res), .ovr_o(ovr)
  );

  // Behavioural integrator and comparator
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_acc <= 0;
    else if (dump) v_acc <= 0;
    else if (sin)  v_acc <= v_acc + vin_u;
    else if (sref) v_acc <= v_acc - VREF;
  end
  assign cmp = (v_acc <= 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Runs one conversion; pulse_k >= 0 re-pulses start that many edges in
  task automatic run_conv(input int vin, input int pulse_k,
                          output int r, output int o, output int lat,
                          output int nd, output int ni, output int nbl);
    int k;
    vin_u = vin;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0; nd = 0; ni = 0; nbl = 0;
    while (k < 2000) begin
      if (dump) nd++;
      if (sin)  ni++;
      if (!busy) nbl++;
      if (valid) break;
      start = (k == pulse_k);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    if (k >= 2000) chk(1'b0, "R6 watchdog", k, 2000);
    r = int'(res); o = int'(ovr); lat = k;
    @(negedge clk);
    chk(!valid, "R6 strobe width", int'(valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int r, o, lat, nd, ni, nbl;
    int hold_r;
    rst_n = 1'b0; start = 1'b0; vin_u = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk({dump, sin, sref, busy, valid, ovr} == 6'b0, "R1 reset outputs",
        int'({dump, sin, sref, busy, valid, ovr}), 0);
    chk(res == '0, "R1 reset result", int'(res), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({dump, sin, sref, busy, valid} == 5'b0, "R1 idle after reset",
        int'({dump, sin, sref, busy, valid}), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_conv(T_VIN[i], -1, r, o, lat, nd, ni, nbl);
      if (T_VIN[i] == 0) chk(r == T_RES[i], "R9 zero input result", r, T_RES[i]);
      else if (T_OVR[i] != 0 || T_RES[i] == FULL)
        chk(r == T_RES[i], "R5 full-scale result", r, T_RES[i]);
      else chk(r == T_RES[i], "R4 result", r, T_RES[i]);
      chk(o == T_OVR[i], "R5 overrange flag", o, T_OVR[i]);
      chk(lat == CLR_CYC + FULL + T_RES[i] + 1, "R6 latency", lat,
          CLR_CYC + FULL + T_RES[i] + 1);
      chk(nd == CLR_CYC, "R2 dump length", nd, CLR_CYC);
      chk(ni == FULL, "R2 integrate length", ni, FULL);
      chk(nbl == 0, "R8 busy coverage", nbl, 0);
      repeat (3) @(negedge clk);
    end

    // R7: result holds after strobe while idle and during next conversion
    hold_r = int'(res);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (res != hold_r[RES_W:0] || valid)
        chk(1'b0, "R7 result hold", int'(res), hold_r);
    end
    chk(int'(res) == hold_r && ovr == 1'b1, "R7 result hold", int'(res), hold_r);
    vin_u = 50;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    chk(int'(res) == hold_r && ovr == 1'b1, "R7 hold during conversion",
        int'(res), hold_r);
    while (!valid) @(negedge clk);
    chk(int'(res) == 52, "R4 result after hold", int'(res), 52);
    repeat (3) @(negedge clk);

    // R8: start pulses while busy are ignored
    run_conv(90, 100, r, o, lat, nd, ni, nbl);
    chk(r == 92, "R8 start while busy result", r, 92);
    chk(lat == CLR_CYC + FULL + 92 + 1, "R8 start while busy latency", lat,
        CLR_CYC + FULL + 93);
    repeat (5) @(negedge clk);
    chk(!busy, "R8 no restart", int'(busy), 0);

    // R1: reset in the middle of integration
    vin_u = 100;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({dump, sin, sref, busy, valid, ovr} == 6'b0, "R1 abandon on reset",
        int'({dump, sin, sref, busy, valid, ovr}), 0);
    chk(res == '0, "R1 result cleared", int'(res), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_conv(37, -1, r, o, lat, nd, ni, nbl);
    chk(r == 39, "R4 result after reset", r, 39);
    chk(nd == CLR_CYC, "R2 dump after reset", nd, CLR_CYC);

    summary();
    $finish;
  end

endmodule